// File: doc/BRIEF.md
# DS3 Alarm Indication and Test Pattern Source

This block feeds the serial transmit path of a DS3 line interface with one bit per clock. A two-bit select input picks what goes out: the user's own data passed through, a continuous stream of ones, a plain alternating one-zero pattern, or a complete DS3 alarm indication signal. The alarm signal carries the full M-frame structure, with overhead bits placed between 84-bit information blocks that hold an alternating pattern.

The block keeps M-frame timing running in every mode and marks the first bit of each frame with a one-cycle strobe. A new selection is taken only at a frame boundary, so downstream logic always sees whole frames of one pattern. Line coding, clock recovery and pulse shaping belong to other blocks.

Top module: `ais_pattern_gen`

## Requirements
- R1: While `rst` is high, `tx_bit_o` and `frame_start_o` are 0. The value on `pat_sel_i` during reset selects the pattern of the first frame after reset.
- R2: `frame_start_o` is high for exactly one cycle in the first output cycle after reset, and then once every 4760 cycles, whatever the selection.
- R3: With select 2'b00, `tx_bit_o` equals the value `user_bit_i` had one cycle earlier.
- R4: With select 2'b01, `tx_bit_o` is 1 on every cycle, and `user_bit_i` has no effect.
- R5: With select 2'b10, `tx_bit_o` alternates every cycle and is 1 in the frame-start cycle; `user_bit_i` has no effect.
- R6: With select 2'b11, a frame is 4760 bits: 7 subframes of 680 bits, each made of 8 blocks that start with one overhead bit followed by 84 information bits. The X bits that open subframes 1 and 2 are 1, so the frame-start bit is 1.
- R7: In the alarm signal, the information bit right after each overhead bit is 1, and the information bits alternate from there.
- R8: In each subframe the overhead bits in order are: a lead bit, F, C, F, C, F, C, F. The lead bit is X=1 in subframes 1 and 2, P=0 in subframes 3 and 4, and 0, 1, 0 in subframes 5, 6 and 7. The four F bits are 1, 0, 0, 1 and every C bit is 0.
- R9: A change of `pat_sel_i` is taken only from its value in the last cycle of a frame, and that value applies to the whole next frame; changes at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one output bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel_i | input | 2 | Pattern select: 00 user, 01 all ones, 10 alternating, 11 alarm signal |
| user_bit_i | input | 1 | User data bit for pass-through mode |
| tx_bit_o | output | 1 | Serial transmit bit, registered |
| frame_start_o | output | 1 | High in the cycle that carries the first bit of an M-frame |

## Verification
On every cycle the assertions check the frame strobe spacing of 4760 cycles, the one-cycle user path, the all-ones and alternating outputs, the 1 on the frame-start bit in alarm mode, and that a new selection is followed at once by a frame start. The exact position and value of each overhead bit, the restart of the information pattern after every overhead bit, and the fact that mid-frame select changes are ignored can only be shown by the bench. It compares every output bit of five consecutive frames in all four modes against an arithmetic frame model, with decoy select changes inside each frame.

// File: rtl/ais_pkg.sv
package ais_pkg;

    // Pattern select encoding, fixed at the block's pins
    typedef enum logic [1:0] {
        SEL_USER = 2'b00,
        SEL_ONES = 2'b01,
        SEL_ALT  = 2'b10,
        SEL_AIS  = 2'b11
    } pat_sel_e;

    localparam int unsigned SUBFRAMES      = 7;
    localparam int unsigned BLOCKS_PER_SUB = 8;
    localparam int unsigned SUB_W          = $clog2(SUBFRAMES);
    localparam int unsigned BLK_W          = $clog2(BLOCKS_PER_SUB);

    // Where the frame timer currently stands
    typedef struct packed {
        logic [SUB_W-1:0] sub;      // subframe index, 0 = first
        logic [BLK_W-1:0] blk;      // block index inside the subframe
        logic             ovh;      // current slot is an overhead bit
        logic             info_one; // information bit value at this slot
        logic             first;    // first bit of the M-frame
        logic             last;     // last bit of the M-frame
    } frame_slot_t;

    function automatic int unsigned frame_bits(input int unsigned info_bits);
        return SUBFRAMES * BLOCKS_PER_SUB * (info_bits + 1);
    endfunction

    // Overhead bit value for a given subframe and block
    function automatic logic ovh_value(input logic [SUB_W-1:0] sub,
                                       input logic [BLK_W-1:0] blk);
        logic v;
        if (blk == '0) begin
            case (sub)
                3'd0, 3'd1: v = 1'b1;  // X bits
                3'd2, 3'd3: v = 1'b0;  // P bits, even payload parity
                3'd5:       v = 1'b1;  // middle M bit
                default:    v = 1'b0;  // outer M bits
            endcase
        end else if (blk[0]) begin
            // F bits in blocks 1,3,5,7: pattern 1 0 0 1
            v = (blk == 3'd1) || (blk == 3'd7);
        end else begin
            v = 1'b0;                  // C bits
        end
        return v;
    endfunction

endpackage

// File: rtl/ais_frame_timer.sv
module ais_frame_timer
    import ais_pkg::*;
#(
    parameter int unsigned INFO_BITS = 84
) (
    input  logic        clk,
    input  logic        rst,
    output frame_slot_t slot_o
);
    localparam int unsigned IDX_W = $clog2(INFO_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(INFO_BITS);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS_PER_SUB - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBFRAMES - 1);

    logic [IDX_W-1:0] idx_q;
    logic [BLK_W-1:0] blk_q;
    logic [SUB_W-1:0] sub_q;
    logic             blk_end;
    logic             sub_end;
    logic             frame_end;

    always_comb begin
        blk_end   = (idx_q == IDX_LAST);
        sub_end   = blk_end && (blk_q == BLK_LAST);
        frame_end = sub_end && (sub_q == SUB_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            blk_q <= '0;
            sub_q <= '0;
        end else begin
            idx_q <= blk_end ? '0 : idx_q + 1'b1;
            if (blk_end) begin
                blk_q <= sub_end ? '0 : blk_q + 1'b1;
            end
            if (sub_end) begin
                sub_q <= frame_end ? '0 : sub_q + 1'b1;
            end
        end
    end

    always_comb begin
        slot_o.sub      = sub_q;
        slot_o.blk      = blk_q;
        slot_o.ovh      = (idx_q == '0);
        slot_o.info_one = idx_q[0];   // first info bit (index 1) is a one
        slot_o.first    = (idx_q == '0) && (blk_q == '0) && (sub_q == '0);
        slot_o.last     = frame_end;
    end

endmodule

// File: rtl/ais_stream_gen.sv
module ais_stream_gen
    import ais_pkg::*;
(
    input  frame_slot_t slot_i,
    output logic        ais_bit_o
);
    always_comb begin
        if (slot_i.ovh) begin
            ais_bit_o = ovh_value(slot_i.sub, slot_i.blk);
        end else begin
            ais_bit_o = slot_i.info_one;
        end
    end
endmodule

// File: rtl/ais_out_stage.sv
module ais_out_stage
    import ais_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pat_sel_e    sel_i,
    input  logic        user_bit_i,
    input  frame_slot_t slot_i,
    input  logic        ais_bit_i,
    output logic        tx_bit_o,
    output logic        frame_start_o,
    output pat_sel_e    act_sel_o
);
    pat_sel_e act_q;
    logic     alt_q;
    logic     tx_q;
    logic     fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= sel_i;
            alt_q <= 1'b1;
            tx_q  <= 1'b0;
            fs_q  <= 1'b0;
        end else begin
            if (slot_i.last) begin
                act_q <= sel_i;
            end
            alt_q <= ~alt_q;
            fs_q  <= slot_i.first;
            case (act_q)
                SEL_USER: tx_q <= user_bit_i;
                SEL_ONES: tx_q <= 1'b1;
                SEL_ALT:  tx_q <= alt_q;
                SEL_AIS:  tx_q <= ais_bit_i;
                default:  tx_q <= 1'b0;
            endcase
        end
    end

    assign tx_bit_o      = tx_q;
    assign frame_start_o = fs_q;
    assign act_sel_o     = act_q;

endmodule

// File: rtl/ais_pattern_gen.sv
module ais_pattern_gen
    import ais_pkg::*;
#(
    parameter int unsigned INFO_BITS = 84
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pat_sel_i,
    input  logic       user_bit_i,
    output logic       tx_bit_o,
    output logic       frame_start_o
);
    frame_slot_t slot;
    logic        ais_bit;
    pat_sel_e    sel_in;
    pat_sel_e    act_sel;

    assign sel_in = pat_sel_e'(pat_sel_i);

    ais_frame_timer #(.INFO_BITS(INFO_BITS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .slot_o (slot)
    );

    ais_stream_gen u_stream (
        .slot_i    (slot),
        .ais_bit_o (ais_bit)
    );

    ais_out_stage u_out (
        .clk           (clk),
        .rst           (rst),
        .sel_i         (sel_in),
        .user_bit_i    (user_bit_i),
        .slot_i        (slot),
        .ais_bit_i     (ais_bit),
        .tx_bit_o      (tx_bit_o),
        .frame_start_o (frame_start_o),
        .act_sel_o     (act_sel)
    );

endmodule

// File: rtl/ais_pattern_gen_chk.sv
module ais_pattern_gen_chk
    import ais_pkg::*;
#(
    parameter int unsigned INFO_BITS = 84
) (
    input logic       clk,
    input logic       rst,
    input logic       user_bit_i,
    input logic       tx_bit_o,
    input logic       frame_start_o,
    input logic [1:0] act_sel
);
    localparam int unsigned FRAME_LEN = frame_bits(INFO_BITS);
    localparam int unsigned GAP_W     = $clog2(FRAME_LEN);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(FRAME_LEN - 1);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            seen_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (frame_start_o) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assert_first_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !seen_q) |-> frame_start_o);

    assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_start_o && seen_q) |-> (gap_q == GAP_LAST));

    assert_strobe_due_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && gap_q == GAP_LAST) |-> frame_start_o);

    assert_user_path_R3: assert property (@(posedge clk) disable iff (rst)
        (act_sel == 2'b00) |=> (tx_bit_o == $past(user_bit_i)));

    assert_all_ones_R4: assert property (@(posedge clk) disable iff (rst)
        (act_sel == 2'b01) |=> tx_bit_o);

    assert_alternate_R5: assert property (@(posedge clk) disable iff (rst)
        (armed_q && act_sel == 2'b10 && $past(act_sel) == 2'b10)
        |=> (tx_bit_o != $past(tx_bit_o)));

    assert_x1_one_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_start_o && act_sel == 2'b11) |-> tx_bit_o);

    assert_switch_at_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !$stable(act_sel)) |=> frame_start_o);

endmodule

bind ais_pattern_gen ais_pattern_gen_chk #(.INFO_BITS(INFO_BITS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .user_bit_i    (user_bit_i),
    .tx_bit_o      (tx_bit_o),
    .frame_start_o (frame_start_o),
    .act_sel       (act_sel)
);

// File: tb/ais_pattern_gen_bench.sv
module ais_pattern_gen_bench;
    localparam int INFO   = 84;
    localparam int BLKLEN = INFO + 1;
    localparam int SUBLEN = 8 * BLKLEN;
    localparam int L      = 7 * SUBLEN;
    localparam int FRAMES = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b11;
    logic       ubit = 1'b0;
    logic       tx;
    logic       fs;
    int         tests = 0;
    int         fails = 0;

    // frame k uses plan[k]; plan[0] is the select held during reset
    logic [1:0] plan [0:FRAMES];

    always #10 clk = ~clk;

    ais_pattern_gen u_ais_pattern_gen (
        .clk           (clk),
        .rst           (rst),
        .pat_sel_i     (sel),
        .user_bit_i    (ubit),
        .tx_bit_o      (tx),
        .frame_start_o (fs)
    );

    task automatic check(input string req, input logic act, input logic exp, input int n);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s bit=%0d actual=%b expected=%b", req, n, act, exp);
        end
    endtask

    // Arithmetic model of the alarm frame (R6, R7, R8)
    function automatic logic ais_model(input int f);
        int sub, r, b, i;
        sub = f / SUBLEN;
        r   = f % SUBLEN;
        b   = r / BLKLEN;
        i   = r % BLKLEN;
        if (i != 0) return (i % 2) == 1;
        if (b == 0) return (sub == 0) || (sub == 1) || (sub == 5);
        return (b == 1) || (b == 7);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R2 actual=stalled expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [1:0]  cur;
        logic [1:0]  pend;
        logic [15:0] lfsr;
        int          f, k, sub, b, i;
        logic        e;
        string       tag;

        plan[0] = 2'b11; plan[1] = 2'b01; plan[2] = 2'b10;
        plan[3] = 2'b00; plan[4] = 2'b11; plan[5] = 2'b01;
        lfsr = 16'hACE1;

        sel = plan[0];
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset tx", tx, 1'b0, -1);
        check("R1 reset strobe", fs, 1'b0, -1);
        cur  = sel;
        pend = sel;
        rst  = 1'b0;

        for (int n = 0; n < FRAMES * L; n++) begin
            f = n % L;
            k = n / L;
            // decoy change mid-frame, then the planned next select (R9)
            if (f == 1234) sel = plan[k+1] ^ 2'b01;
            if (f == 3000) sel = plan[k+1];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ubit = lfsr[0];
            if (f == 0 && n > 0) cur = pend;
            if (f == L - 1) pend = sel;

            @(posedge clk);
            @(negedge clk);

            check("R2 frame strobe", fs, (f == 0), n);

            sub = f / SUBLEN;
            b   = (f % SUBLEN) / BLKLEN;
            i   = f % BLKLEN;
            case (cur)
                2'b00:   begin e = ubit;           tag = "R3 user pass-through"; end
                2'b01:   begin e = 1'b1;           tag = "R4 all ones"; end
                2'b10:   begin e = (n % 2) == 0;   tag = "R5 alternating"; end
                default: begin
                    e = ais_model(f);
                    if (i != 0)                  tag = "R7 info bit";
                    else if (b == 0 && sub < 2)  tag = "R6 X bit";
                    else                         tag = "R8 overhead bit";
                end
            endcase
            if (f == 0) tag = (n == 0) ? "R1 first frame select" : "R9 frame-boundary switch";
            check(tag, tx, e, n);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule